// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers eight interrupt lines into one request toward a processor and hands back an 8-bit interrupt type through a two-strobe acknowledge. A rising edge on a line marks that level as pending. The block holds a pending set and an in-service set. A fixed-priority resolver raises the processor request only when the best pending level outranks every level now being serviced. This lets a more urgent handler pre-empt a less urgent one, and it holds back anything of equal or lower rank.

The processor answers with two active-low strobes on the acknowledge input. On the first strobe the block moves the winning level from pending to in-service and leaves the data bus floating. On the second strobe it drives the type byte, which is built from a software-written base and the level number. It releases the bus when the strobe ends. A small write port carries two commands: set the type base, and a nonspecific end-of-interrupt that retires the most urgent in-service level.

Top module: `nest_irq_ctrl`

## Requirements
- R1: A low-to-high change on `irq_in[n]` marks level n pending. A line that stays high marks it pending only once.
- R2: Priority is fixed. Level 0 is the most urgent and level 7 the least. When several levels are pending, the acknowledge serves the lowest-numbered one.
- R3: A pending level raises no request while any level of equal or higher priority is in service.
- R4: `cpu_req` is high whenever no acknowledge is under way and a pending level outranks every in-service level. This covers a higher level arriving during a lower handler.
- R5: A falling strobe on `inta_n` with no acknowledge under way moves the winning level into service and clears its pending mark. `vec_drive` stays low and `data_bus` is not driven during this strobe.
- R6: On the second falling strobe, `data_bus` carries the type byte and `vec_drive` is high, while `cpu_req` goes low. When `inta_n` returns high, the bus is released and `vec_drive` goes low.
- R7: A write with `wr_eoi`=1 retires the lowest-numbered in-service level and ignores `wr_data`. A pending level that then becomes eligible raises `cpu_req` again.
- R8: A write with `wr_eoi`=0 stores `wr_data[7:3]` as the type base. The type byte is the base in bits 7:3 and the level number in bits 2:0.
- R9: If no level is eligible at the first strobe, the handshake still completes. It returns the type byte for level 7 and puts no level into service.
- R10: After reset, nothing is pending or in service, `cpu_req` and `vec_drive` are low, and the base is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Interrupt lines, edge-sensitive, index 0 most urgent |
| cpu_req | output | 1 | Interrupt request to the processor |
| inta_n | input | 1 | Active-low acknowledge strobe, synchronized inside |
| wr_en | input | 1 | Command write strobe, one cycle |
| wr_eoi | input | 1 | 1 selects end-of-interrupt, 0 selects a base write |
| wr_data | input | 8 | Write data, bits 7:3 used for the base |
| data_bus | inout | 8 | Type byte during the second strobe, otherwise high impedance |
| vec_drive | output | 1 | High while the block drives `data_bus` |

## Verification
The hardest state to reach is a pending level that is held back only by an in-service level of equal rank. It shows whether the end-of-interrupt retired the right bit. The stimulus reaches it by putting level 4 in service, dropping and raising line 4 so that it is pending again, and then nesting level 2 above it. The first end-of-interrupt must leave the request low, because level 4 is still in service and blocks its own pending copy. Only the second one may raise it. The strobe with nothing eligible is reached by acknowledging with no line having risen since the last service.

// File: rtl/nirq_pkg.sv
package nirq_pkg;
  localparam int NLVL   = 8;
  localparam int LVL_W  = $clog2(NLVL);
  localparam int VEC_W  = 8;
  localparam int BASE_W = VEC_W - LVL_W;

  typedef struct packed {
    logic             hit;
    logic [LVL_W-1:0] idx;
  } pick_t;

  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_WAIT2 = 2'd1, PH_DRIVE = 2'd2} ack_ph_t;

  // lowest set index wins (index 0 is most urgent)
  function automatic pick_t top_pick(input logic [NLVL-1:0] v);
    pick_t p;
    p = '0;
    for (int i = NLVL - 1; i >= 0; i--) begin
      if (v[i]) begin
        p.hit = 1'b1;
        p.idx = LVL_W'(i);
      end
    end
    return p;
  endfunction

  function automatic logic [NLVL-1:0] lvl_mask(input logic [LVL_W-1:0] idx);
    return NLVL'(1) << idx;
  endfunction

  function automatic logic [VEC_W-1:0] make_vec(input logic [BASE_W-1:0] base,
                                                input logic [LVL_W-1:0] idx);
    return {base, idx};
  endfunction
endpackage

// File: rtl/nirq_edge_cap.sv
module nirq_edge_cap #(
  parameter int W = nirq_pkg::NLVL
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lines,
  output logic [W-1:0] rise
);
  logic [W-1:0] lines_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lines_q <= '0;
    else        lines_q <= lines;
  end

  assign rise = lines & ~lines_q;
endmodule

// File: rtl/nirq_resolver.sv
module nirq_resolver
  import nirq_pkg::*;
(
  input  logic [NLVL-1:0]  irr,
  input  logic [NLVL-1:0]  isr,
  output logic             eligible,
  output logic [LVL_W-1:0] win_idx,
  output pick_t            isr_top
);
  pick_t irr_top;

  always_comb begin
    irr_top  = top_pick(irr);
    isr_top  = top_pick(isr);
    win_idx  = irr_top.idx;
    // fully nested: equal or more urgent in-service level blocks
    eligible = irr_top.hit && (!isr_top.hit || (irr_top.idx < isr_top.idx));
  end
endmodule

// File: rtl/nirq_ack_seq.sv
module nirq_ack_seq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inta_n,
  output logic ack_fall,
  output logic ack_rise
);
  localparam int CW = SYNC_STAGES + 1;
  logic [CW-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[CW-2:0], inta_n};
  end

  logic now_lvl, old_lvl;
  assign now_lvl  = chain[CW-2];
  assign old_lvl  = chain[CW-1];
  assign ack_fall = old_lvl & ~now_lvl;
  assign ack_rise = ~old_lvl & now_lvl;
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLVL-1:0] irq_in,
  output logic            cpu_req,
  input  logic            inta_n,
  input  logic            wr_en,
  input  logic            wr_eoi,
  input  logic [VEC_W-1:0] wr_data,
  inout  wire [VEC_W-1:0] data_bus,
  output logic            vec_drive
);
  logic [NLVL-1:0]   irr, isr, rise;
  logic [BASE_W-1:0] base;
  logic [LVL_W-1:0]  lvl_q, win_idx;
  ack_ph_t           phase;
  pick_t             isr_top;
  logic              eligible, ack_fall, ack_rise;

  // named internal events
  logic            commit, second, release_bus, eoi_fire;
  logic [NLVL-1:0] take_mask, retire_mask;

  nirq_edge_cap #(.W(NLVL)) u_edge (
    .clk(clk), .rst_n(rst_n), .lines(irq_in), .rise(rise)
  );

  nirq_resolver u_res (
    .irr(irr), .isr(isr), .eligible(eligible), .win_idx(win_idx), .isr_top(isr_top)
  );

  nirq_ack_seq #(.SYNC_STAGES(SYNC_STAGES)) u_ack (
    .clk(clk), .rst_n(rst_n), .inta_n(inta_n), .ack_fall(ack_fall), .ack_rise(ack_rise)
  );

  assign commit      = ack_fall && (phase == PH_IDLE);
  assign second      = ack_fall && (phase == PH_WAIT2);
  assign release_bus = ack_rise && (phase == PH_DRIVE);
  assign eoi_fire    = wr_en && wr_eoi;
  assign take_mask   = (commit && eligible) ? lvl_mask(win_idx) : '0;
  assign retire_mask = (eoi_fire && isr_top.hit) ? lvl_mask(isr_top.idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr   <= '0;
      isr   <= '0;
      base  <= '0;
      lvl_q <= '0;
      phase <= PH_IDLE;
    end else begin
      irr <= (irr & ~take_mask) | rise;
      isr <= (isr & ~retire_mask) | take_mask;
      if (wr_en && !wr_eoi) base <= wr_data[VEC_W-1:LVL_W];
      if (commit) lvl_q <= eligible ? win_idx : '1;
      unique case (phase)
        PH_IDLE:  if (commit)      phase <= PH_WAIT2;
        PH_WAIT2: if (second)      phase <= PH_DRIVE;
        PH_DRIVE: if (release_bus) phase <= PH_IDLE;
        default:                   phase <= PH_IDLE;
      endcase
    end
  end

  assign cpu_req   = (phase == PH_WAIT2) || ((phase == PH_IDLE) && eligible);
  assign vec_drive = (phase == PH_DRIVE);
  assign data_bus  = vec_drive ? make_vec(base, lvl_q) : 'z;
endmodule

// File: rtl/nirq_checker.sv
module nirq_checker
  import nirq_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            cpu_req,
  input logic            vec_drive,
  input logic            eligible,
  input logic            commit,
  input logic            eoi_fire,
  input logic [NLVL-1:0] isr,
  input ack_ph_t         phase
);
  a_r4_req_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && eligible) |-> cpu_req);

  a_r3_blocked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && !eligible) |-> !cpu_req);

  a_r5_commit_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && eligible && !eoi_fire) |=> ($countones(isr) == $past($countones(isr)) + 1));

  a_r5_no_drive_first: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WAIT2) |-> !vec_drive);

  a_r6_drive_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    vec_drive |-> !cpu_req);

  a_r7_eoi_retires_one: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_fire && (isr != '0) && !commit) |=> ($countones(isr) == $past($countones(isr)) - 1));

  a_r9_spurious_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !eligible && !eoi_fire) |=> (isr == $past(isr)));
endmodule

bind nest_irq_ctrl nirq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .vec_drive(vec_drive),
  .eligible(eligible), .commit(commit), .eoi_fire(eoi_fire), .isr(isr), .phase(phase)
);

// File: tb/nest_irq_ctrl_test.sv
module nest_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       inta_n = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_eoi = 1'b0;
  logic [7:0] wr_data = '0;
  wire  [7:0] dbus;
  logic       cpu_req, vec_drive;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [4:0] base_m = '0;
  logic       drv_seen = 1'b0;

  always #4 clk = ~clk;

  nest_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cpu_req(cpu_req), .inta_n(inta_n),
    .wr_en(wr_en), .wr_eoi(wr_eoi), .wr_data(wr_data), .data_bus(dbus), .vec_drive(vec_drive)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // model of the type byte: base in 7:3, level in 2:0 (R8)
  function automatic logic [7:0] vec_of(input int lvl);
    return {base_m, 3'(lvl)};
  endfunction

  // monitor: pop one expected type byte per bus-drive episode
  always @(negedge clk) begin
    if (vec_drive && !drv_seen) begin
      if (exp_q.size() == 0) chk(1'b0, "R6 unexpected drive", dbus, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(dbus === e, t, dbus, e);
      end
    end
    drv_seen <= vec_drive;
  end

  // driver: full two-strobe acknowledge, pushes the expected byte
  task automatic do_ack(input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    inta_n = 1'b0; step(5);
    chk(vec_drive == 1'b0, "R5 bus undriven in first strobe", vec_drive, 0);
    chk(cpu_req == 1'b1, "R5 request held between strobes", cpu_req, 1);
    inta_n = 1'b1; step(5);
    inta_n = 1'b0; step(5);
    chk(vec_drive == 1'b1, "R6 drive in second strobe", vec_drive, 1);
    chk(cpu_req == 1'b0, "R6 request dropped in second strobe", cpu_req, 0);
    inta_n = 1'b1; step(5);
    chk(vec_drive == 1'b0, "R6 bus released", vec_drive, 0);
  endtask

  task automatic wr(input bit eoi, input logic [7:0] d);
    wr_en = 1'b1; wr_eoi = eoi; wr_data = d;
    step(1);
    wr_en = 1'b0; wr_eoi = 1'b0; wr_data = '0;
    if (!eoi) base_m = d[7:3];
    step(2);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    // R10 reset state
    chk(cpu_req == 1'b0, "R10 cpu_req after reset", cpu_req, 0);
    chk(vec_drive == 1'b0, "R10 vec_drive after reset", vec_drive, 0);

    // R1 edge on line 4 raises request
    irq_in[4] = 1'b1; step(3);
    chk(cpu_req == 1'b1, "R1 edge on line 4 requests", cpu_req, 1);
    do_ack(vec_of(4), "R5 R8 type for level 4 base 0");
    chk(cpu_req == 1'b0, "R5 pending cleared after service", cpu_req, 0);

    // R3 lower level and equal level blocked
    irq_in[6] = 1'b1; step(3);
    chk(cpu_req == 1'b0, "R3 lower level blocked", cpu_req, 0);
    irq_in[4] = 1'b0; step(2);
    irq_in[4] = 1'b1; step(3);
    chk(cpu_req == 1'b0, "R3 equal level blocked", cpu_req, 0);

    // R4 nesting by more urgent level
    irq_in[2] = 1'b1; step(3);
    chk(cpu_req == 1'b1, "R4 higher level nests", cpu_req, 1);
    do_ack(vec_of(2), "R4 nested type level 2");

    // R7 end-of-interrupt retires level 2 only, data ignored
    wr(1'b1, 8'hFF);
    chk(cpu_req == 1'b0, "R7 retires most urgent, 4 still blocks", cpu_req, 0);
    wr(1'b1, 8'h00);
    chk(cpu_req == 1'b1, "R7 re-request after retire", cpu_req, 1);
    // R2 levels 4 and 6 pending, 4 wins
    do_ack(vec_of(4), "R2 lower index served first");
    wr(1'b1, 8'h00);
    chk(cpu_req == 1'b1, "R7 level 6 now eligible", cpu_req, 1);
    wr(1'b0, 8'hA8);
    do_ack(vec_of(6), "R8 programmed base with level 6");
    wr(1'b1, 8'h00);

    // R1 steady high lines do not re-request
    step(4);
    chk(cpu_req == 1'b0, "R1 steady lines stay quiet", cpu_req, 0);

    // R9 acknowledge with nothing eligible
    do_ack(vec_of(7), "R9 spurious returns level 7");
    irq_in[7] = 1'b1; step(3);
    chk(cpu_req == 1'b1, "R9 no level left in service", cpu_req, 1);
    do_ack(vec_of(7), "R9 real level 7 served");
    wr(1'b1, 8'h00);

    // R2 simultaneous edges on 5 and 1
    irq_in = '0; step(3);
    irq_in[5] = 1'b1; irq_in[1] = 1'b1; step(3);
    do_ack(vec_of(1), "R2 simultaneous, level 1 first");
    chk(cpu_req == 1'b0, "R3 level 5 held behind 1", cpu_req, 0);
    wr(1'b1, 8'h00);
    do_ack(vec_of(5), "R2 then level 5");
    wr(1'b1, 8'h00);
    step(4);
    chk(exp_q.size() == 0, "R6 every expected type seen", exp_q.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule